// File: doc/BRIEF.md
# Word Packer with Flush

This block gathers 32-bit words that arrive up to three per clock, each lane with its own enable bit, and lays them back to back in a wide internal buffer. Each time four words have gathered it presents one 128-bit beat. Words beyond the fourth stay in the buffer and lead the following beat. The output has no back-pressure. A beat is shown for exactly one cycle and is consumed on the next clock edge.

A flush strobe closes the stream. The words presented with the flush are taken in first. The block then drains whatever it holds: first any full beat, then one partial beat that reports how many of its words are real. After that it is empty. If the buffer is empty when the flush takes effect, no beat appears. While a drain is in progress, input words are dropped. A synchronous reset empties the block at any time.

Top module: `word_packer`

## Requirements
- R1: While `rst` is high at a clock edge, the buffer, the word count and the drain state are cleared. In the following cycle `outValid` is 0 and `outCount` is 0. Words held before the reset never reappear.
- R2: Words leave in arrival order. Within a cycle, lane 0 (`inData[31:0]`) comes before lane 1 (`inData[63:32]`), and lane 1 before lane 2 (`inData[95:64]`). Word k of a beat sits in `outData[32k+31:32k]`.
- R3: A full beat is shown in the cycle after the clock edge at which four or more words are held: `outValid`=1 and `outCount`=4. The beat is removed at the next edge.
- R4: Held words beyond the fourth are kept, and they become the first words of the next beat.
- R5: `inEn` must be 3'b000, 3'b001, 3'b011 or 3'b111, which add 0, 1, 2 or 3 words. Lanes whose enable bit is 0 contribute nothing, whatever their data.
- R6: After a flush edge, if the block holds 1 to 3 words, one partial beat is shown with `outCount` equal to that number. Words above `outCount` read 0. The cycle after that beat holds no beat, and the block is empty.
- R7: A flush that finds the block empty produces no beat.
- R8: Words presented in the same cycle as `flush` are accepted and included in the drain.
- R9: If a flush leaves more than four words held, a full beat is shown first. The partial beat with the remainder is shown in the next cycle.
- R10: From the edge after a flush until the drain ends, input words are discarded. This includes the cycle that shows the partial beat, or the empty cycle that ends a drain. A flush during a drain has no effect.
- R11: Whenever `outValid` is 0, `outCount` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | 96 | Three 32-bit input words, lane 0 in the low bits |
| inEn | input | 3 | Per-lane enable, contiguous from bit 0 |
| flush | input | 1 | Drain request strobe |
| outData | output | 128 | Output beat, word 0 in the low bits |
| outValid | output | 1 | Beat present this cycle |
| outCount | output | 3 | Number of real words in the beat (1 to 4), 0 when idle |

## Verification
The outputs depend only on registered state, so every result is due in the cycle right after the clock edge that takes the stimulus. A flush shows its partial beat one cycle after the flush edge, or two cycles after it when a full beat must go out first. The bench drives each stimulus on the falling edge and samples the outputs on the next falling edge, after exactly one rising edge, before it drives anything new. Ignored inputs are proven by the first word of the next beat, which is the word the bench expects to lead it.

// File: rtl/wp_pkg.sv
package wp_pkg;

  localparam int unsigned DEF_WORD_W = 32;
  localparam int unsigned DEF_LANES = 3;
  localparam int unsigned DEF_BEAT_WORDS = 4;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic shiftOut;   // drop one full beat from the bottom of the buffer
    logic accept;     // merge the masked input words
    logic clearAll;   // empty the buffer (end of a drain)
  } wp_strobe_t;

endpackage

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES,
  parameter int unsigned BEAT_WORDS = DEF_BEAT_WORDS,
  parameter int unsigned CNT_W = 3,
  parameter int unsigned OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] inEn,
  input  logic             flush,
  output wp_strobe_t       strobe,
  output logic [OFF_W-1:0] offset,
  output logic             outValid,
  output logic [CNT_W-1:0] outCount,
  output logic [CNT_W-1:0] wordCnt,
  output logic             drainFlag
);

  localparam logic [CNT_W-1:0] BEAT_CNT = CNT_W'(BEAT_WORDS);

  logic [CNT_W-1:0] cntQ, cntN;
  logic             drainQ, drainN;
  logic [CNT_W-1:0] newWords;
  logic             beatReady;
  logic             partialCycle;
  logic             acceptNow;

  // Number of enabled lanes
  always_comb begin
    newWords = '0;
    for (int l = 0; l < int'(LANES); l++) begin
      newWords = newWords + CNT_W'(inEn[l]);
    end
  end

  always_comb begin
    beatReady    = cntQ[OFF_W];
    partialCycle = drainQ && !beatReady;
    acceptNow    = !drainQ && (|inEn);
    if (partialCycle) begin
      cntN   = '0;
      drainN = 1'b0;
    end else begin
      cntN   = cntQ - (beatReady ? BEAT_CNT : '0) + (acceptNow ? newWords : '0);
      drainN = drainQ | flush;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ   <= '0;
      drainQ <= 1'b0;
    end else begin
      cntQ   <= cntN;
      drainQ <= drainN;
    end
  end

  assign strobe.shiftOut = beatReady;
  assign strobe.accept   = acceptNow;
  assign strobe.clearAll = partialCycle;
  assign offset          = cntQ[OFF_W-1:0];

  assign outValid  = beatReady | (drainQ && (cntQ != '0));
  assign outCount  = beatReady ? BEAT_CNT : (drainQ ? cntQ : '0);
  assign wordCnt   = cntQ;
  assign drainFlag = drainQ;

endmodule

// File: rtl/wp_data.sv
module wp_data
  import wp_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned LANES = DEF_LANES,
  parameter int unsigned BEAT_WORDS = DEF_BEAT_WORDS,
  parameter int unsigned OFF_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [WORD_W*LANES-1:0]   inData,
  input  logic [LANES-1:0]          inEn,
  input  wp_strobe_t                strobe,
  input  logic [OFF_W-1:0]          offset,
  output logic [WORD_W*BEAT_WORDS-1:0] outData
);

  localparam int unsigned LANE_BITS = WORD_W * LANES;
  localparam int unsigned BEAT_W    = WORD_W * BEAT_WORDS;
  localparam int unsigned BUF_W     = WORD_W * (BEAT_WORDS + LANES);

  logic [LANE_BITS-1:0] maskedIn;
  logic [BUF_W-1:0]     bufQ, bufN, baseVal, insVal;

  // Force disabled lanes to zero
  generate
    for (genvar l = 0; l < int'(LANES); l++) begin : gLane
      assign maskedIn[l*WORD_W +: WORD_W] = inEn[l] ? inData[l*WORD_W +: WORD_W] : '0;
    end
  endgenerate

  always_comb begin
    if (strobe.clearAll)      baseVal = '0;
    else if (strobe.shiftOut) baseVal = bufQ >> BEAT_W;
    else                      baseVal = bufQ;
    insVal = {{(BUF_W-LANE_BITS){1'b0}}, maskedIn} << (int'(offset) * int'(WORD_W));
    bufN   = strobe.accept ? (baseVal | insVal) : baseVal;
  end

  always_ff @(posedge clk) begin
    if (rst) bufQ <= '0;
    else     bufQ <= bufN;
  end

  assign outData = bufQ[BEAT_W-1:0];

endmodule

// File: rtl/word_packer.sv
module word_packer
  import wp_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned LANES = DEF_LANES,
  parameter int unsigned BEAT_WORDS = DEF_BEAT_WORDS
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [WORD_W*LANES-1:0]       inData,
  input  logic [LANES-1:0]              inEn,
  input  logic                          flush,
  output logic [WORD_W*BEAT_WORDS-1:0]  outData,
  output logic                          outValid,
  output logic [$clog2(BEAT_WORDS+LANES)-1:0] outCount
);

  localparam int unsigned CNT_W = $clog2(BEAT_WORDS + LANES);
  localparam int unsigned OFF_W = $clog2(BEAT_WORDS);

  wp_strobe_t       strobe;
  logic [OFF_W-1:0] offset;
  logic [CNT_W-1:0] wordCnt;
  logic             drainFlag;

  wp_ctrl #(
    .LANES(LANES), .BEAT_WORDS(BEAT_WORDS), .CNT_W(CNT_W), .OFF_W(OFF_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inEn(inEn), .flush(flush),
    .strobe(strobe), .offset(offset),
    .outValid(outValid), .outCount(outCount),
    .wordCnt(wordCnt), .drainFlag(drainFlag)
  );

  wp_data #(
    .WORD_W(WORD_W), .LANES(LANES), .BEAT_WORDS(BEAT_WORDS), .OFF_W(OFF_W)
  ) u_data (
    .clk(clk), .rst(rst), .inData(inData), .inEn(inEn),
    .strobe(strobe), .offset(offset), .outData(outData)
  );

endmodule

// File: rtl/word_packer_chk.sv
module word_packer_chk #(
  parameter int unsigned LANES = 3,
  parameter int unsigned BEAT_WORDS = 4,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] inEn,
  input logic             outValid,
  input logic [CNT_W-1:0] outCount,
  input logic [CNT_W-1:0] wordCnt,
  input logic             drainFlag
);

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!outValid && outCount == '0));

  p_mask_contig_r5: assert property (@(posedge clk) disable iff (rst)
    (inEn & LANES'(inEn + 1'b1)) == '0);

  p_beat_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (int'(wordCnt) >= int'(BEAT_WORDS) && !drainFlag && inEn == '0)
      |=> int'(wordCnt) == int'($past(wordCnt)) - int'(BEAT_WORDS));

  p_partial_empty_r6: assert property (@(posedge clk) disable iff (rst)
    (outValid && int'(outCount) < int'(BEAT_WORDS)) |=> (wordCnt == '0 && !drainFlag && !outValid));

  p_drain_no_add_r10: assert property (@(posedge clk) disable iff (rst)
    drainFlag |=> wordCnt <= $past(wordCnt));

  p_idle_count_r11: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> outCount == '0);

  p_count_range_r3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outCount != '0 && int'(outCount) <= int'(BEAT_WORDS)));

endmodule

bind word_packer word_packer_chk #(
  .LANES(LANES), .BEAT_WORDS(BEAT_WORDS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .inEn(inEn), .outValid(outValid),
  .outCount(outCount), .wordCnt(wordCnt), .drainFlag(drainFlag)
);

// File: tb/word_packer_test.sv
`timescale 1ns/1ps
module word_packer_test;

  localparam int W = 32;
  localparam int L = 3;
  localparam int B = 4;
  localparam logic [31:0] BASE = 32'h1000_0000;

  // en, flush, expValid, expCount, expFirst, reqCode
  typedef struct packed {
    logic [2:0] en;
    logic       fl;
    logic       v;
    logic [2:0] c;
    logic [7:0] first;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam logic [19:0] VEC [0:NV-1] = '{
    {3'd1, 1'b0, 1'b0, 3'd0, 8'd0,  4'd2},  // one word
    {3'd3, 1'b0, 1'b0, 3'd0, 8'd0,  4'd2},  // three held
    {3'd1, 1'b0, 1'b1, 3'd4, 8'd0,  4'd3},  // R3 beat 0..3
    {3'd7, 1'b0, 1'b0, 3'd0, 8'd0,  4'd11}, // three held
    {3'd7, 1'b0, 1'b1, 3'd4, 8'd4,  4'd4},  // R4 six held
    {3'd0, 1'b0, 1'b0, 3'd0, 8'd0,  4'd11}, // two carried
    {3'd3, 1'b0, 1'b1, 3'd4, 8'd8,  4'd5},  // R5 lane2 junk
    {3'd1, 1'b1, 1'b1, 3'd1, 8'd12, 4'd8},  // R8 flush with word
    {3'd0, 1'b0, 1'b0, 3'd0, 8'd0,  4'd6},  // R6 empty after
    {3'd0, 1'b1, 1'b0, 3'd0, 8'd0,  4'd7},  // R7 flush empty
    {3'd0, 1'b0, 1'b0, 3'd0, 8'd0,  4'd7},
    {3'd7, 1'b0, 1'b0, 3'd0, 8'd0,  4'd2},
    {3'd7, 1'b1, 1'b1, 3'd4, 8'd13, 4'd9},  // R9 full first
    {3'd7, 1'b0, 1'b1, 3'd2, 8'd17, 4'd9},  // R9 partial, input dropped
    {3'd1, 1'b0, 1'b0, 3'd0, 8'd0,  4'd10}, // dropped
    {3'd1, 1'b0, 1'b0, 3'd0, 8'd0,  4'd10},
    {3'd1, 1'b1, 1'b1, 3'd2, 8'd23, 4'd10}, // R10 first word 23
    {3'd0, 1'b0, 1'b0, 3'd0, 8'd0,  4'd6},
    {3'd7, 1'b0, 1'b0, 3'd0, 8'd0,  4'd2},
    {3'd1, 1'b1, 1'b1, 3'd4, 8'd25, 4'd8},  // exactly four on flush
    {3'd0, 1'b0, 1'b0, 3'd0, 8'd0,  4'd7},  // no partial
    {3'd0, 1'b0, 1'b0, 3'd0, 8'd0,  4'd7},
    {3'd3, 1'b0, 1'b0, 3'd0, 8'd0,  4'd2},
    {3'd0, 1'b1, 1'b1, 3'd2, 8'd29, 4'd6},
    {3'd0, 1'b0, 1'b0, 3'd0, 8'd0,  4'd11}
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [W*L-1:0] inData = '0;
  logic [L-1:0]   inEn = '0;
  logic           flush = 1'b0;
  logic [W*B-1:0] outData;
  logic           outValid;
  logic [2:0]     outCount;

  int checks = 0;
  int failures = 0;
  int seq = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  word_packer uut (
    .clk(clk), .rst(rst), .inData(inData), .inEn(inEn), .flush(flush),
    .outData(outData), .outValid(outValid), .outCount(outCount)
  );

  function automatic string reqName(input logic [3:0] code);
    case (code)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive lanes: enabled lanes carry sequence words, disabled ones junk
  task automatic driveWords(input logic [2:0] en, input logic fl);
    int n = 0;
    for (int l = 0; l < L; l++) begin
      if (en[l]) begin
        inData[l*W +: W] = BASE + 32'(seq + l);
        n++;
      end else begin
        inData[l*W +: W] = 32'hDEAD_0000 | 32'(l);
      end
    end
    inEn  = en;
    flush = fl;
    seq   = seq + n;
  endtask

  function automatic logic [127:0] expBeat(input int first, input int cnt);
    logic [127:0] e = '0;
    for (int j = 0; j < B; j++) begin
      if (j < cnt) e[j*W +: W] = BASE + 32'(first + j);
    end
    return e;
  endfunction

  task automatic checkOut(input string req, input logic v, input int c, input int first);
    check(outValid == v, req, "outValid", 128'(outValid), 128'(v));
    check(int'(outCount) == c, req, "outCount", 128'(outCount), 128'(c));
    if (v) check(outData == expBeat(first, c), (c < B) ? "R6" : "R2", "outData",
                 outData, expBeat(first, c));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state after reset
    checkOut("R1", 1'b0, 0, 0);
    check(outData == '0, "R1", "outData cleared", outData, '0);
    rst = 1'b0;

    // Table of vectors
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VEC[i]);
      driveWords(v.en, v.fl);
      @(negedge clk);
      checkOut(reqName(v.req), v.v, int'(v.c), int'(v.first));
    end

    // R1: reset mid-stream discards held words
    driveWords(3'd7, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    inEn = '0;
    flush = 1'b0;
    @(negedge clk);
    checkOut("R1", 1'b0, 0, 0);
    rst = 1'b0;
    driveWords(3'd1, 1'b0);
    @(negedge clk);
    checkOut("R1", 1'b0, 0, 0);
    begin
      int lead;
      lead = seq - 1;
      driveWords(3'd0, 1'b1);
      @(negedge clk);
      checkOut("R1", 1'b1, 1, lead);
    end
    driveWords(3'd0, 1'b0);
    @(negedge clk);
    checkOut("R11", 1'b0, 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule